// File: doc/BRIEF.md
# Guest-Side Reset Handshake Monitor

This block sits on the guest side of a virtualised accelerator. It watches message words that the host posts into the receive mailbox and follows the two-phase function-level-reset exchange that the host starts.

The exchange has two phases:

- **Start.** A reset-start message arrives. The block acknowledges it with a one-cycle pulse, permanently withdraws its runtime capability bit and raises a halt output. The halt tells the rest of the guest to stop issuing work.
- **Holdoff and poll.** The block lets a fixed number of millisecond ticks pass without looking at the mailbox. It then watches for the reset-done message within a bounded window of ticks.
- **Success.** When the done message arrives, the block acknowledges it, drops halt and pulses a reinitialise request.
- **Timeout.** If the window runs out first, the block drops halt, returns to idle and raises a sticky error flag. The flag stays set until it is explicitly cleared.

Message codes, holdoff length, poll window and the tick-edge mode are parameters. Each message is examined only when the receive interrupt enable is high.

Top module: `vf_reset_watch`

## Requirements
- R1: After reset, rx_ack, halt, reinit_req and timeout_err are 0 and runtime_cap is 1.
- R2: Message code 2 means reset start and code 3 means reset done. While idle, codes 0, 1 and 3 produce no acknowledge and no change of any output.
- R3: A strobe on rx_valid with rx_irq_en low is not observed, in any state.
- R4: An observed code 2 while idle gives a one-cycle rx_ack in the cycle after the strobe. In that same cycle halt rises and runtime_cap falls.
- R5: Once runtime_cap has fallen it stays 0 until reset, including after a successful reset-done.
- R6: During holdoff, messages are ignored. Polling starts at the HOLDOFF_TICKS-th tick counted after the start was accepted (12 by default), so a done message before that tick is not acknowledged.
- R7: An observed code 3 while polling gives, in the next cycle, rx_ack and reinit_req, each high for exactly one cycle. In that same cycle halt goes low.
- R8: If the POLL_TICKS-th tick of the poll window (150 by default) passes with no done message, timeout_err rises and halt falls in the next cycle. No acknowledge or reinit_req is given, and the block returns to idle.
- R9: timeout_err stays 1 until err_clear is high at a clock edge. A timeout in the same cycle as err_clear leaves it at 1.
- R10: A done message in the same cycle as the final poll tick counts as success, not timeout.
- R11: With SYNC_TICK=1, ms_tick counts once per rising edge, however long it stays high.
- R12: A further code 2 during holdoff or polling is not acknowledged and does not restart the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_irq_en | input | 1 | Receive interrupt enable; gates rx_valid |
| rx_valid | input | 1 | Strobe marking a new message word |
| rx_code | input | CODE_W | Received message code |
| ms_tick | input | 1 | Millisecond time base |
| err_clear | input | 1 | Clears the sticky timeout flag |
| rx_ack | output | 1 | One-cycle receive acknowledge |
| halt | output | 1 | Guest execution halted |
| reinit_req | output | 1 | One-cycle request to reinitialise |
| timeout_err | output | 1 | Sticky poll timeout flag |
| runtime_cap | output | 1 | Runtime capability bit |

## Verification
The bench uses the default parameters: an 8-bit code, a 12-tick holdoff, a 150-tick poll window and edge-qualified ticks. With these values both windows are short enough to walk tick by tick, so the bench reaches the exact last-tick boundaries. It checks one tick before expiry and checks the expiring tick itself alone, together with a done message and together with an error clear. Edge qualification lets the bench hold ms_tick high for several cycles and show from the holdoff length that it counted once.

// File: rtl/vfrw_pkg.sv
package vfrw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HOLD = 2'd1,
      ST_POLL = 2'd2
   } vfrw_state_e;

   typedef struct packed {
      logic notify;
      logic done;
   } vfrw_msg_t;
endpackage

// File: rtl/vfrw_tick_gate.sv
module vfrw_tick_gate #(
   parameter bit SYNC_TICK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   output logic tick_ev
);
   generate
      if (SYNC_TICK) begin : g_edge
         logic tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= tick_in;
         end
         assign tick_ev = tick_in & ~tick_q;
      end else begin : g_level
         assign tick_ev = tick_in;
      end
   endgenerate
endmodule

// File: rtl/vfrw_msg_decode.sv
module vfrw_msg_decode
   import vfrw_pkg::*;
#(
   parameter int unsigned CODE_W      = 8,
   parameter int unsigned NOTIFY_CODE = 2,
   parameter int unsigned DONE_CODE   = 3
) (
   input  logic              rx_irq_en,
   input  logic              rx_valid,
   input  logic [CODE_W-1:0] rx_code,
   output vfrw_msg_t         msg
);
   localparam logic [CODE_W-1:0] NOTIFY_V = CODE_W'(NOTIFY_CODE);
   localparam logic [CODE_W-1:0] DONE_V   = CODE_W'(DONE_CODE);

   logic seen;
   assign seen       = rx_valid & rx_irq_en;
   assign msg.notify = seen && (rx_code == NOTIFY_V);
   assign msg.done   = seen && (rx_code == DONE_V);
endmodule

// File: rtl/vfrw_tick_timer.sv
module vfrw_tick_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick_ev,
   output logic             expire
);
   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          remain <= '0;
      else if (load)                       remain <= load_val;
      else if (tick_ev && remain != '0)    remain <= remain - 1'b1;
   end

   assign expire = tick_ev && (remain == CNT_W'(1));
endmodule

// File: rtl/vfrw_seq.sv
module vfrw_seq
   import vfrw_pkg::*;
#(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned HOLDOFF = 12,
   parameter int unsigned POLL    = 150
) (
   input  logic             clk,
   input  logic             rst_n,
   input  vfrw_msg_t        msg,
   input  logic             expire,
   input  logic             err_clear,
   output logic             timer_load,
   output logic [CNT_W-1:0] timer_val,
   output logic             rx_ack,
   output logic             halt,
   output logic             reinit_req,
   output logic             timeout_err,
   output logic             runtime_cap
);
   localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLDOFF);
   localparam logic [CNT_W-1:0] POLL_LD = CNT_W'(POLL);

   vfrw_state_e st, st_nx;
   logic accept_start, accept_done, hold_over, poll_lapse;

   always_comb begin
      accept_start = (st == ST_IDLE) && msg.notify;
      accept_done  = (st == ST_POLL) && msg.done;
      hold_over    = (st == ST_HOLD) && expire;
      poll_lapse   = (st == ST_POLL) && expire && !msg.done;
      timer_load   = accept_start || hold_over;
      timer_val    = (st == ST_IDLE) ? HOLD_LD : POLL_LD;
      st_nx        = st;
      unique case (st)
         ST_IDLE: if (accept_start)             st_nx = ST_HOLD;
         ST_HOLD: if (hold_over)                st_nx = ST_POLL;
         ST_POLL: if (accept_done || poll_lapse) st_nx = ST_IDLE;
         default:                               st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         rx_ack      <= 1'b0;
         halt        <= 1'b0;
         reinit_req  <= 1'b0;
         timeout_err <= 1'b0;
         runtime_cap <= 1'b1;
      end else begin
         st         <= st_nx;
         rx_ack     <= accept_start || accept_done;
         reinit_req <= accept_done;
         if (accept_start)                   halt <= 1'b1;
         else if (accept_done || poll_lapse) halt <= 1'b0;
         if (accept_start) runtime_cap <= 1'b0;
         if (poll_lapse)     timeout_err <= 1'b1;
         else if (err_clear) timeout_err <= 1'b0;
      end
   end

   // R4
   ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ack |=> !rx_ack);
   // R3
   ack_needs_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ack |-> $past(msg.notify || msg.done));
   // R5
   cap_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !runtime_cap |=> !runtime_cap);
   // R7
   reinit_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reinit_req |-> (rx_ack && !halt));
   // R8
   halt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(halt) |-> (reinit_req || timeout_err));
   // R4
   halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt) |-> (rx_ack && !runtime_cap));
endmodule

// File: rtl/vf_reset_watch.sv
module vf_reset_watch
   import vfrw_pkg::*;
#(
   parameter int unsigned CODE_W        = 8,
   parameter int unsigned NOTIFY_CODE   = 2,
   parameter int unsigned DONE_CODE     = 3,
   parameter int unsigned HOLDOFF_TICKS = 12,
   parameter int unsigned POLL_TICKS    = 150,
   parameter bit          SYNC_TICK     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_irq_en,
   input  logic              rx_valid,
   input  logic [CODE_W-1:0] rx_code,
   input  logic              ms_tick,
   input  logic              err_clear,
   output logic              rx_ack,
   output logic              halt,
   output logic              reinit_req,
   output logic              timeout_err,
   output logic              runtime_cap
);
   localparam int unsigned MAX_TICKS = (HOLDOFF_TICKS > POLL_TICKS) ? HOLDOFF_TICKS : POLL_TICKS;
   localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

   generate
      if (HOLDOFF_TICKS < 1) begin : g_bad_hold
         $error("HOLDOFF_TICKS must be at least 1");
      end
      if (POLL_TICKS < 1) begin : g_bad_poll
         $error("POLL_TICKS must be at least 1");
      end
      if (NOTIFY_CODE == DONE_CODE) begin : g_bad_codes
         $error("start and done codes must differ");
      end
      if (CODE_W < 2 || NOTIFY_CODE >= (1 << CODE_W) || DONE_CODE >= (1 << CODE_W)) begin : g_bad_w
         $error("CODE_W too narrow for the message codes");
      end
   endgenerate

   logic             tick_ev, expire, timer_load;
   logic [CNT_W-1:0] timer_val;
   vfrw_msg_t        msg;

   vfrw_tick_gate #(.SYNC_TICK(SYNC_TICK)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_in(ms_tick), .tick_ev(tick_ev)
   );

   vfrw_msg_decode #(.CODE_W(CODE_W), .NOTIFY_CODE(NOTIFY_CODE), .DONE_CODE(DONE_CODE)) u_dec (
      .rx_irq_en(rx_irq_en), .rx_valid(rx_valid), .rx_code(rx_code), .msg(msg)
   );

   vfrw_tick_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(timer_val),
      .tick_ev(tick_ev), .expire(expire)
   );

   vfrw_seq #(.CNT_W(CNT_W), .HOLDOFF(HOLDOFF_TICKS), .POLL(POLL_TICKS)) u_seq (
      .clk(clk), .rst_n(rst_n), .msg(msg), .expire(expire), .err_clear(err_clear),
      .timer_load(timer_load), .timer_val(timer_val), .rx_ack(rx_ack), .halt(halt),
      .reinit_req(reinit_req), .timeout_err(timeout_err), .runtime_cap(runtime_cap)
   );
endmodule

// File: tb/test_vf_reset_watch.sv
module test_vf_reset_watch;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;
   localparam int NVEC       = 9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_irq_en = 1'b0, rx_valid = 1'b0, ms_tick = 1'b0, err_clear = 1'b0;
   logic [7:0] rx_code = '0;
   logic       rx_ack, halt, reinit_req, timeout_err, runtime_cap;
   int         n_chk = 0, n_bad = 0;

   // vector: {irq_en, valid, code[7:0], tick, expected {ack,halt,reinit,err,cap}}
   localparam logic [15:0] VECS [NVEC] = '{
      {1'b0, 1'b0, 8'd0, 1'b0, 5'b00001},
      {1'b1, 1'b1, 8'd0, 1'b0, 5'b00001},
      {1'b1, 1'b1, 8'd1, 1'b0, 5'b00001},
      {1'b1, 1'b1, 8'd3, 1'b0, 5'b00001},
      {1'b0, 1'b1, 8'd2, 1'b0, 5'b00001},
      {1'b1, 1'b1, 8'd2, 1'b0, 5'b11000},
      {1'b1, 1'b0, 8'd0, 1'b0, 5'b01000},
      {1'b1, 1'b1, 8'd3, 1'b0, 5'b01000},
      {1'b1, 1'b1, 8'd2, 1'b0, 5'b01000}
   };
   localparam string VTAG [NVEC] = '{"R1", "R2", "R2", "R2", "R3", "R4", "R4", "R6", "R12"};

   vf_reset_watch i_vf_reset_watch (
      .clk(clk), .rst_n(rst_n), .rx_irq_en(rx_irq_en), .rx_valid(rx_valid),
      .rx_code(rx_code), .ms_tick(ms_tick), .err_clear(err_clear),
      .rx_ack(rx_ack), .halt(halt), .reinit_req(reinit_req),
      .timeout_err(timeout_err), .runtime_cap(runtime_cap)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [4:0] outs();
      return {rx_ack, halt, reinit_req, timeout_err, runtime_cap};
   endfunction

   task automatic chk(input string tag, input logic [4:0] exp);
      n_chk++;
      if (outs() !== exp) begin
         n_bad++;
         $display("FAIL %s: {ack,halt,reinit,err,cap} = %b, expected %b", tag, outs(), exp);
      end
   endtask

   task automatic cyc(input logic en, input logic v, input logic [7:0] code,
                      input logic tk, input logic clr);
      rx_irq_en = en; rx_valid = v; rx_code = code; ms_tick = tk; err_clear = clr;
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         cyc(1'b1, 1'b0, 8'd0, 1'b1, 1'b0);
         cyc(1'b1, 1'b0, 8'd0, 1'b0, 1'b0);
      end
   endtask

   task automatic start_and_hold();
      cyc(1'b1, 1'b1, 8'd2, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 8'd0, 1'b0, 1'b0);
      ticks(12);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung, expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 in reset", 5'b00001);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", 5'b00001);

      for (int i = 0; i < NVEC; i++) begin
         cyc(VECS[i][15], VECS[i][14], VECS[i][13:6], VECS[i][5], 1'b0);
         chk(VTAG[i], VECS[i][4:0]);
      end

      // R11: held tick counts once; 1 + 10 = 11 ticks, still in holdoff
      cyc(1'b1, 1'b0, 8'd0, 1'b1, 1'b0);
      cyc(1'b1, 1'b0, 8'd0, 1'b1, 1'b0);
      cyc(1'b1, 1'b0, 8'd0, 1'b1, 1'b0);
      cyc(1'b1, 1'b0, 8'd0, 1'b0, 1'b0);
      ticks(10);
      cyc(1'b1, 1'b1, 8'd3, 1'b0, 1'b0);
      chk("R11 R6 done before 12th tick ignored", 5'b01000);
      ticks(1);
      chk("R6 polling after 12th tick", 5'b01000);
      cyc(1'b0, 1'b1, 8'd3, 1'b0, 1'b0);
      chk("R3 done with enable low", 5'b01000);
      cyc(1'b1, 1'b1, 8'd1, 1'b0, 1'b0);
      chk("R2 other code while polling", 5'b01000);
      cyc(1'b1, 1'b1, 8'd2, 1'b0, 1'b0);
      chk("R12 start while polling", 5'b01000);
      cyc(1'b1, 1'b1, 8'd3, 1'b0, 1'b0);
      chk("R7 done accepted", 5'b10100);
      cyc(1'b1, 1'b0, 8'd0, 1'b0, 1'b0);
      chk("R7 R5 pulses end, cap stays low", 5'b00000);

      // R8 timeout
      start_and_hold();
      ticks(149);
      chk("R8 one tick before timeout", 5'b01000);
      cyc(1'b1, 1'b0, 8'd0, 1'b1, 1'b0);
      chk("R8 timeout", 5'b00010);
      cyc(1'b1, 1'b1, 8'd3, 1'b0, 1'b0);
      chk("R9 sticky, late done ignored", 5'b00010);
      cyc(1'b1, 1'b0, 8'd0, 1'b0, 1'b1);
      chk("R9 cleared", 5'b00000);

      // R9 set wins over clear
      start_and_hold();
      ticks(149);
      cyc(1'b1, 1'b0, 8'd0, 1'b1, 1'b1);
      chk("R9 timeout beats clear", 5'b00010);
      cyc(1'b1, 1'b0, 8'd0, 1'b0, 1'b1);
      chk("R9 clear afterwards", 5'b00000);

      // R10 done on the final tick
      start_and_hold();
      ticks(149);
      cyc(1'b1, 1'b1, 8'd3, 1'b1, 1'b0);
      chk("R10 done beats timeout", 5'b10100);
      cyc(1'b1, 1'b0, 8'd0, 1'b0, 1'b0);
      chk("R10 no error afterwards", 5'b00000);

      // R1 reset mid-sequence
      cyc(1'b1, 1'b1, 8'd2, 1'b0, 1'b0);
      chk("R4 start again", 5'b11000);
      rst_n = 1'b0;
      cyc(1'b1, 1'b0, 8'd0, 1'b0, 1'b0);
      chk("R1 reset restores", 5'b00001);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule